// File: doc/BRIEF.md
# E3 G.832 Overhead Error Injector

This block sits in the transmit path of an E3 framer that follows the G.832 frame structure. It takes the outgoing serial bit stream one bit at a time and, on command, corrupts one bit of a chosen overhead field. It can corrupt the frame alignment pattern, the BIP-8 parity byte, the remote defect bit or the remote error bit. The surrounding framer still generates the frame, computes the parity and applies line coding.

Software arms an error by writing a 1 to one of four single-shot request bits. An armed request waits for the next bit position that belongs to its field. The block inverts that one bit and the request then clears itself. Each type has its own armed flag, so several errors can be pending together and each lands on its own field.

A frame-position counter inside the block tells the upstream framer which bit it is expected to present next. It also drives the per-field markers used for injection. Injection results are defined only for overhead fields that the framer generates internally or takes from a register.

Top module: `g832_oh_err_inj`

## Requirements
- R1: While `rst_ni` is low, and on the first sample after it rises, `armed_o`, `inj_o`, `data_valid_o` and `data_o` are all 0 and `sof_o` is 1.
- R2: A position counter advances by one on each cycle with `bit_en_i` high and wraps from FRAME_BYTES*8-1 (4295 by default) to 0. `sof_o` is high at position 0. The `mark_o` bits are indexed 0 = alignment, 1 = parity, 2 = remote defect, 3 = remote error. With the defaults they are high at positions 0, 480, 1440 and 1441 respectively. These are the first bit of byte 0, the MSB of byte 60, and the MSB and next bit of byte 180.
- R3: A bit presented with `bit_en_i` high appears on `data_o` one cycle later with `data_valid_o` high. It is unchanged unless an injection applies to it.
- R4: A cycle with `req_wr_i` high sets `armed_o[k]` on the next cycle for each `req_i[k]` that is 1. Bits of `req_i` that are 0 change nothing. A write to a type that is already armed has no effect, so it still yields exactly one injection.
- R5: An armed alignment error inverts the bit at position 0, the first bit of the alignment pattern.
- R6: An armed parity error inverts the bit at the MSB position of the parity byte.
- R7: An armed remote-defect error inverts the MSB of the maintenance byte, whatever value that bit carried.
- R8: An armed remote-error error inverts the second bit of the maintenance byte, whatever value that bit carried.
- R9: When an injection is applied, `inj_o[k]` pulses for one cycle aligned with the corrupted `data_o` bit and `armed_o[k]` clears in that same cycle. Later frames pass unaltered.
- R10: Requests of different types armed together are each applied once, at their own fields, within the same frame.
- R11: A request written in the very cycle its target bit passes is not applied to that bit. It stays armed and lands on the same field in the next frame.
- R12: In a cycle with `bit_en_i` low, the position does not move, `data_o` holds, `data_valid_o` and `inj_o` are 0 on the next cycle, and armed requests stay armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | A stream bit is presented this cycle |
| data_i | input | 1 | Transmit bit for the current position |
| req_wr_i | input | 1 | Request register write strobe |
| req_i | input | 4 | Request bits (0 alignment, 1 parity, 2 remote defect, 3 remote error) |
| sof_o | output | 1 | Current position is the first bit of the frame |
| mark_o | output | 4 | Per-type target markers for the current position |
| data_valid_o | output | 1 | `data_o` carries a new bit |
| data_o | output | 1 | Transmit bit after optional inversion |
| inj_o | output | 4 | One-cycle injection pulse per type |
| armed_o | output | 4 | Pending request per type |

## Verification
On every cycle, the assertions check the following. At most one marker is high at a time. The counter wraps at the end of the frame. A write arms a request. Idle cycles leave the armed state and the output untouched. An armed request that meets its marker produces a pulse, clears itself and inverts exactly the bit that went in. Only the bench's scenarios can show the following: each field sits at its stated bit position, a request fires only once per arming, several armed requests all land in one frame, and a write in the target cycle defers to the next frame. Those checks run against a reference model under random enables, data and writes.

// File: rtl/g832_inj_pkg.sv
package g832_inj_pkg;
  localparam int NUM_ERR = 4;
  typedef enum logic [1:0] {
    ERR_FA  = 2'd0,
    ERR_BIP = 2'd1,
    ERR_RDI = 2'd2,
    ERR_REI = 2'd3
  } err_e;
  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/g832_frame_pos.sv
module g832_frame_pos
  import g832_inj_pkg::*;
#(
  parameter int ROW_BYTES   = 60,
  parameter int FRAME_BYTES = 537,
  parameter int EM_ROW      = 1,
  parameter int MA_ROW      = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  output logic     sof_o,
  output err_vec_t marks_o
);
  localparam int FRAME_BITS = FRAME_BYTES * 8;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int EM_BIT     = EM_ROW * ROW_BYTES * 8;
  localparam int MA_BIT     = MA_ROW * ROW_BYTES * 8;

  logic [PW-1:0] pos_q;
  logic          last;

  assign last = (pos_q == PW'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (bit_en_i) pos_q <= last ? '0 : pos_q + 1'b1;
  end

  assign sof_o = (pos_q == '0);

  always_comb begin
    marks_o          = '0;
    marks_o[ERR_FA]  = (pos_q == '0);
    marks_o[ERR_BIP] = (pos_q == PW'(EM_BIT));
    marks_o[ERR_RDI] = (pos_q == PW'(MA_BIT));
    marks_o[ERR_REI] = (pos_q == PW'(MA_BIT + 1));
  end

  a_r2_marks_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(marks_o));
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && last) |=> sof_o);
  a_r12_pos_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(pos_q));
endmodule

// File: rtl/g832_err_arm.sv
module g832_err_arm
  import g832_inj_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  err_vec_t req_i,
  input  err_vec_t hit_i,
  output err_vec_t armed_o
);
  for (genvar k = 0; k < NUM_ERR; k++) begin : g_arm
    logic armed_q;
    // write only arms an idle type; a pass while armed disarms
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed_q <= 1'b0;
      else         armed_q <= (armed_q & ~hit_i[k]) | (wr_i & req_i[k] & ~armed_q);
    end
    assign armed_o[k] = armed_q;

    a_r4_arm_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && req_i[k] && !armed_q) |=> armed_q);
    a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_q && !(wr_i && req_i[k])) |=> !armed_q);
  end
endmodule

// File: rtl/g832_oh_err_inj.sv
module g832_oh_err_inj
  import g832_inj_pkg::*;
#(
  parameter int ROW_BYTES   = 60,
  parameter int FRAME_BYTES = 537,
  parameter int EM_ROW      = 1,
  parameter int MA_ROW      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               data_i,
  input  logic               req_wr_i,
  input  logic [NUM_ERR-1:0] req_i,
  output logic               sof_o,
  output logic [NUM_ERR-1:0] mark_o,
  output logic               data_valid_o,
  output logic               data_o,
  output logic [NUM_ERR-1:0] inj_o,
  output logic [NUM_ERR-1:0] armed_o
);
  err_vec_t marks, hit, armed, inj_d, inj_q;
  logic     flip, data_q, valid_q;

  g832_frame_pos #(
    .ROW_BYTES  (ROW_BYTES),
    .FRAME_BYTES(FRAME_BYTES),
    .EM_ROW     (EM_ROW),
    .MA_ROW     (MA_ROW)
  ) i_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .sof_o   (sof_o),
    .marks_o (marks)
  );

  assign hit = bit_en_i ? marks : '0;

  g832_err_arm i_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (req_wr_i),
    .req_i  (req_i),
    .hit_i  (hit),
    .armed_o(armed)
  );

  assign inj_d = hit & armed;
  assign flip  = |inj_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= 1'b0;
      valid_q <= 1'b0;
      inj_q   <= '0;
    end else begin
      valid_q <= bit_en_i;
      inj_q   <= inj_d;
      if (bit_en_i) data_q <= data_i ^ flip;
    end
  end

  assign mark_o       = marks;
  assign data_valid_o = valid_q;
  assign data_o       = data_q;
  assign inj_o        = inj_q;
  assign armed_o      = armed;

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_chk
    a_r9_inj_at_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bit_en_i && armed_o[k] && mark_o[k]) |=> (inj_o[k] && !armed_o[k]));
  end

  // R5 R6 R7 R8: the pulsed bit is the inverse of what came in
  a_r5_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_o != '0) |-> (data_o != $past(data_i)));
  a_r3_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> data_valid_o);
  a_r12_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> (!data_valid_o && inj_o == '0 && $stable(data_o)));
  a_r12_armed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !req_wr_i) |=> $stable(armed_o));
endmodule

// File: tb/test_g832_oh_err_inj.sv
module test_g832_oh_err_inj;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 537 * 8;
  localparam int EM_BIT     = 480;
  localparam int MA_BIT     = 1440;
  localparam int WDOG       = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, din = 1'b0, req_wr = 1'b0;
  logic [3:0] req = '0;
  logic       sof, dvalid, dout;
  logic [3:0] mark, inj, armed;

  g832_oh_err_inj i_g832_oh_err_inj (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .data_i(din),
    .req_wr_i(req_wr), .req_i(req), .sof_o(sof), .mark_o(mark),
    .data_valid_o(dvalid), .data_o(dout), .inj_o(inj), .armed_o(armed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned n_chk = 0, n_fail = 0, cyc = 0;
  int unsigned pos_m = 0;
  logic [3:0]  arm_m = '0, exp_inj = '0;
  logic        exp_d = 1'b0, exp_v = 1'b0;
  int unsigned cnt_inj [4] = '{0, 0, 0, 0};
  bit          done = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cyc, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [3:0] marks_of(int unsigned p);
    return {p == MA_BIT + 1, p == MA_BIT, p == EM_BIT, p == 0};
  endfunction

  function automatic string data_req(logic [3:0] e);
    if (e[0]) return "R5";
    if (e[1]) return "R6";
    if (e[2]) return "R7";
    if (e[3]) return "R8";
    return "R3";
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0h exp %0h (pos %0d)", r, act, exp, pos_m);
    end
  endtask

  // drive one cycle at negedge, model the edge, compare at next negedge
  task automatic step(bit en, bit d, bit wr, logic [3:0] rq);
    logic [3:0] mk, hit, wm;
    bit_en = en; din = d; req_wr = wr; req = rq;
    mk = marks_of(pos_m);
    chk(mark == mk, "R2", mark, mk);
    chk(sof == (pos_m == 0), "R2", sof, pos_m == 0);
    hit = en ? mk : 4'b0;
    wm  = wr ? rq : 4'b0;
    exp_inj = hit & arm_m;
    exp_v   = en;
    if (en) begin
      exp_d = d ^ (|exp_inj);
      pos_m = (pos_m == FRAME_BITS - 1) ? 0 : pos_m + 1;
    end
    arm_m = (arm_m & ~hit) | (wm & ~arm_m);
    for (int k = 0; k < 4; k++) if (exp_inj[k]) cnt_inj[k]++;
    @(negedge clk);
    chk(dvalid == exp_v, en ? "R3" : "R12", dvalid, exp_v);
    chk(dout == exp_d, data_req(exp_inj), dout, exp_d);
    chk(inj == exp_inj, "R9", inj, exp_inj);
    chk(armed == arm_m, "R4", armed, arm_m);
  endtask

  task automatic run_to(int unsigned target);
    do step(1'b1, 1'($urandom), 1'b0, 4'b0);
    while (pos_m != target);
  endtask

  int unsigned snap [4];

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(armed == 0 && inj == 0 && dvalid == 0 && dout == 0, "R1",
        {armed, inj, dvalid, dout}, 0);
    chk(sof == 1'b1, "R1", sof, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(armed == 0 && inj == 0 && dvalid == 0 && dout == 0 && sof, "R1",
        {armed, inj, dvalid, dout, sof}, 1);

    // random phase
    for (int f = 0; f < 12; f++) begin
      do step(($urandom % 8) != 0, 1'($urandom), ($urandom % 400) == 0,
              4'($urandom));
      while (pos_m != 7);
    end
    repeat (2) run_to(7);  // let pending requests drain
    chk(armed == 0, "R9", armed, 0);

    // R10: all four armed together, one frame
    run_to(5);
    snap = cnt_inj;
    step(1'b1, 1'b0, 1'b1, 4'hF);
    run_to(5);
    for (int k = 0; k < 4; k++)
      chk(cnt_inj[k] == snap[k] + 1, "R10", cnt_inj[k], snap[k] + 1);
    chk(armed == 0, "R10", armed, 0);

    // R11: write in the cycle the alignment bit passes
    run_to(0);
    snap = cnt_inj;
    step(1'b1, 1'b1, 1'b1, 4'b0001);
    chk(inj == 0 && cnt_inj[0] == snap[0], "R11", inj, 0);
    chk(armed == 4'b0001, "R11", armed, 1);
    run_to(1);
    chk(cnt_inj[0] == snap[0] + 1, "R11", cnt_inj[0], snap[0] + 1);

    // R4: rewrite while armed, and a write of zeros
    run_to(10);
    snap = cnt_inj;
    step(1'b1, 1'b0, 1'b1, 4'b0010);
    step(1'b1, 1'b0, 1'b1, 4'b0000);
    chk(armed == 4'b0010, "R4", armed, 2);
    run_to(200);
    step(1'b1, 1'b1, 1'b1, 4'b0010);
    run_to(10);
    chk(cnt_inj[1] == snap[1] + 1, "R4", cnt_inj[1], snap[1] + 1);

    // R12 / R7: idle at the remote-defect bit, then release
    step(1'b1, 1'b0, 1'b1, 4'b0100);
    run_to(MA_BIT);
    snap = cnt_inj;
    repeat (20) step(1'b0, 1'b1, 1'b0, 4'b0);
    chk(armed == 4'b0100 && inj == 0, "R12", {armed, inj}, 8'h40);
    step(1'b1, 1'b1, 1'b0, 4'b0);
    chk(inj == 4'b0100 && dout == 1'b0, "R7", {inj, dout}, 8);
    // R8 with a zero bit
    step(1'b1, 1'b0, 1'b1, 4'b1000);
    run_to(MA_BIT + 1);
    step(1'b1, 1'b0, 1'b0, 4'b0);
    chk(inj == 4'b1000 && dout == 1'b1, "R8", {inj, dout}, 17);
    run_to(3);
    chk(armed == 0, "R9", armed, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule